// File: doc/BRIEF.md
# DRAM Refresh and Start-up Scheduler

This block keeps an asynchronous DRAM alive. It brings the memory up from reset and then issues refresh cycles at a steady average rate. After reset it stays quiet for a fixed start-up pause. It then runs a fixed number of warm-up refresh cycles on its own, without asking for the bus. Only after the last of these has finished precharging does it raise `ready`, which lets normal traffic through.

From then on an interval timer marks each point at which one row's refresh becomes due. Each due refresh is added to a small saturating backlog. While the backlog is non-zero and no refresh is in progress, the block raises `req` toward the access controller. A grant that arrives in the same cycle as `req` starts one refresh cycle, and the block drives the row and column strobes itself until that cycle ends. Two refresh styles are supported, and the style is picked per cycle by `mode_row_only`:
- In column-before-row style the column strobe leads the row strobe, and the memory's internal row counter is used.
- In row-only style the block presents a row address from its own counter while only the row strobe pulses.

All timing values are parameters in clock counts or microseconds.

Top module: `dram_refresh_sched`

## Requirements
- R1: In normal operation one refresh becomes due every INTERVAL_CLKS = CLK_PER_US*REFRESH_MS*1000/ROWS clocks (125 at the defaults). With `grant` held high, any window of K whole intervals contains exactly K row-strobe falls.
- R2: After reset is released, `ras_n`, `cas_n` and `req` stay high, high and low for the first PAUSE_US*CLK_PER_US clocks (800 at the defaults). The first strobe activity appears no later than 4 clocks after that pause.
- R3: After the pause, exactly INIT_CYCLES (8) refresh cycles of the selected style run without any grant. `ready` rises only after the eighth cycle's precharge has ended, and `req` stays low while `ready` is low.
- R4: In column-before-row style (`mode_row_only`=0 when the cycle starts), `cas_n` is low for at least CAS_SETUP clocks before `ras_n` falls. It then stays low for at least CAS_HOLD clocks of the row-strobe low time.
- R5: In column-before-row style `addr_oe` stays low for the whole cycle.
- R6: In row-only style (`mode_row_only`=1) `cas_n` stays high and `addr_oe` is high while `ras_n` is low. `row_addr` equals an 8-bit counter that is 0 after reset and advances by one, modulo 256, after every row-only cycle, warm-up cycles included.
- R7: `ras_n` is low for exactly RAS_PULSE clocks (4) per cycle and high for at least RAS_PRECH clocks (3) between cycles.
- R8: `req` stays high until granted. A refresh starts only when `req` and `grant` are both high at the same clock edge, and the style is sampled at that edge.
- R9: Due refreshes that are not yet granted accumulate in a backlog that saturates at 2^BACKLOG_W-1 (7). Once `grant` is held high, the backlog is drained by that many back-to-back cycles.
- R10: Synchronous active-high `rst` returns the block to the pause state with `ready` low, strobes high and the row counter at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_row_only | input | 1 | Refresh style for the next cycle: 1 row-only, 0 column-before-row |
| grant | input | 1 | Bus grant from the access controller |
| req | output | 1 | Refresh request, held until granted |
| ready | output | 1 | Memory initialised; normal traffic allowed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | 8 | Row address for row-only refresh |
| addr_oe | output | 1 | Block is driving `row_addr` onto the address bus |

## Verification
The hardest state to reach from the ports is a saturated backlog. It needs nine or more due intervals to pass with the grant held off, and then the drain has to be observed without the next interval tick landing inside the counting window. The stimulus table reaches this by locking onto the first rise of `req`. It then waits a computed number of whole intervals plus a small offset before granting, so the window of back-to-back cycles closes before the next tick. Row counter wrap-around is reached by a long run of row-only refreshes granted on every request.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [1:0] {
        PH_PAUSE = 2'd0,
        PH_INIT  = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_CSETUP = 2'd1,
        SQ_RASLO  = 2'd2,
        SQ_PRECH  = 2'd3
    } seq_e;

    typedef enum logic {
        RF_CBR = 1'b0,
        RF_ROW = 1'b1
    } rf_mode_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic addr_oe;
    } strobe_t;

    function automatic int interval_clks(input int clk_per_us, input int ms, input int rows);
        return (clk_per_us * ms * 1000) / rows;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rfsh_phase_ctrl.sv
module rfsh_phase_ctrl
    import rfsh_pkg::*;
#(
    parameter int PAUSE_CLKS    = 800,
    parameter int INTERVAL_CLKS = 125,
    parameter int INIT_CYCLES   = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   seq_done,
    output phase_e phase,
    output logic   tick
);
    localparam int CW = $clog2(((PAUSE_CLKS > INTERVAL_CLKS) ? PAUSE_CLKS : INTERVAL_CLKS) + 1);
    localparam int IW = $clog2(INIT_CYCLES + 1);

    logic [CW-1:0] cnt;
    logic [IW-1:0] icnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_PAUSE;
            cnt   <= '0;
            icnt  <= '0;
        end else begin
            case (phase)
                PH_PAUSE: begin
                    if (cnt == CW'(PAUSE_CLKS - 1)) begin
                        phase <= PH_INIT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_INIT: begin
                    if (seq_done) begin
                        if (icnt == IW'(INIT_CYCLES - 1)) begin
                            phase <= PH_RUN;
                            cnt   <= '0;
                        end
                        icnt <= icnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == CW'(INTERVAL_CLKS - 1)) cnt <= '0;
                    else                                cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    assign tick = (phase == PH_RUN) && (cnt == CW'(INTERVAL_CLKS - 1));

    // R3
    init_to_run_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN && $past(phase) == PH_INIT) |-> $past(seq_done));

    // R1
    tick_only_run_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
    parameter int BACKLOG_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 take,
    output logic                 pending,
    output logic [BACKLOG_W-1:0] level
);
    localparam logic [BACKLOG_W-1:0] MAXV = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
        end else begin
            case ({tick, take})
                2'b10:   if (level != MAXV) level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign pending = (level != '0);

    // R9
    backlog_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (level == MAXV && tick && !take) |=> (level == MAXV));

    // R9
    backlog_under_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> (level != '0));

endmodule

// File: rtl/rfsh_strobe_seq.sv
module rfsh_strobe_seq
    import rfsh_pkg::*;
#(
    parameter int RAS_PULSE = 4,
    parameter int RAS_PRECH = 3,
    parameter int CAS_SETUP = 1,
    parameter int CAS_HOLD  = 2,
    parameter int ROW_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  rf_mode_e         mode,
    output strobe_t          strb,
    output logic [ROW_W-1:0] row_addr,
    output logic             idle,
    output logic             done
);
    localparam int MAXP = max3(RAS_PULSE, RAS_PRECH, CAS_SETUP);
    localparam int CW   = $clog2(MAXP + 1);

    seq_e             state;
    rf_mode_e         mode_q;
    logic [CW-1:0]    cnt;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            mode_q <= RF_CBR;
            cnt    <= '0;
            row_q  <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        mode_q <= mode;
                        cnt    <= '0;
                        state  <= (mode == RF_CBR) ? SQ_CSETUP : SQ_RASLO;
                    end
                end
                SQ_CSETUP: begin
                    if (cnt == CW'(CAS_SETUP - 1)) begin
                        state <= SQ_RASLO;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_RASLO: begin
                    if (cnt == CW'(RAS_PULSE - 1)) begin
                        state <= SQ_PRECH;
                        cnt   <= '0;
                        if (mode_q == RF_ROW) row_q <= row_q + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == CW'(RAS_PRECH - 1)) begin
                        state <= SQ_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        strb.ras_n   = (state != SQ_RASLO);
        strb.cas_n   = !((state == SQ_CSETUP) ||
                         (state == SQ_RASLO && mode_q == RF_CBR && cnt < CW'(CAS_HOLD)));
        strb.addr_oe = (state == SQ_RASLO) && (mode_q == RF_ROW);
    end

    assign row_addr = row_q;
    assign idle     = (state == SQ_IDLE);
    assign done     = (state == SQ_PRECH) && (cnt == CW'(RAS_PRECH - 1));

    // R4
    cbr_order_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(strb.ras_n) && mode_q == RF_CBR) |-> (!strb.cas_n && $past(strb.cas_n) == 1'b0));

    // R5
    cbr_noaddr_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == RF_CBR) |-> !strb.addr_oe);

    // R6
    row_only_cas_chk: assert property (@(posedge clk) disable iff (rst)
        (!strb.ras_n && mode_q == RF_ROW) |-> (strb.cas_n && strb.addr_oe));

    // R6
    row_inc_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(strb.ras_n) && mode_q == RF_ROW) |-> (row_q == $past(row_q) + 1'b1));

    // R7
    prech_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(strb.ras_n) |=> strb.ras_n);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import rfsh_pkg::*;
#(
    parameter int CLK_PER_US  = 8,
    parameter int ROWS        = 256,
    parameter int REFRESH_MS  = 4,
    parameter int PAUSE_US    = 100,
    parameter int INIT_CYCLES = 8,
    parameter int RAS_PULSE   = 4,
    parameter int RAS_PRECH   = 3,
    parameter int CAS_SETUP   = 1,
    parameter int CAS_HOLD    = 2,
    parameter int BACKLOG_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     mode_row_only,
    input  logic                     grant,
    output logic                     req,
    output logic                     ready,
    output logic                     ras_n,
    output logic                     cas_n,
    output logic [$clog2(ROWS)-1:0]  row_addr,
    output logic                     addr_oe
);
    localparam int ROW_W         = $clog2(ROWS);
    localparam int PAUSE_CLKS    = PAUSE_US * CLK_PER_US;
    localparam int INTERVAL_CLKS = interval_clks(CLK_PER_US, REFRESH_MS, ROWS);

    phase_e               phase;
    logic                 tick;
    logic                 pending;
    logic [BACKLOG_W-1:0] level;
    logic                 seq_idle;
    logic                 seq_done;
    logic                 start;
    logic                 take;
    strobe_t              strb;

    rfsh_phase_ctrl #(
        .PAUSE_CLKS   (PAUSE_CLKS),
        .INTERVAL_CLKS(INTERVAL_CLKS),
        .INIT_CYCLES  (INIT_CYCLES)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .seq_done(seq_done),
        .phase   (phase),
        .tick    (tick)
    );

    rfsh_backlog #(
        .BACKLOG_W(BACKLOG_W)
    ) u_backlog (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .take   (take),
        .pending(pending),
        .level  (level)
    );

    rfsh_strobe_seq #(
        .RAS_PULSE(RAS_PULSE),
        .RAS_PRECH(RAS_PRECH),
        .CAS_SETUP(CAS_SETUP),
        .CAS_HOLD (CAS_HOLD),
        .ROW_W    (ROW_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mode    (rf_mode_e'(mode_row_only)),
        .strb    (strb),
        .row_addr(row_addr),
        .idle    (seq_idle),
        .done    (seq_done)
    );

    assign ready   = (phase == PH_RUN);
    assign req     = ready && pending && seq_idle;
    assign take    = req && grant;
    assign start   = seq_idle && ((phase == PH_INIT) || take);
    assign ras_n   = strb.ras_n;
    assign cas_n   = strb.cas_n;
    assign addr_oe = strb.addr_oe;

    // R2
    pause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PAUSE) |-> (ras_n && cas_n && !req));

    // R3
    ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !req);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !grant) |=> req);

    // R8
    grant_start_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && $fell(ras_n) == 1'b0 && $fell(cas_n)) |-> $past(req && grant));

endmodule

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;

    localparam int CLK_PERIOD  = 10;
    localparam int CLK_PER_US  = 8;
    localparam int ROWS        = 256;
    localparam int REFRESH_MS  = 4;
    localparam int PAUSE_US    = 100;
    localparam int INIT_CYCLES = 8;
    localparam int RAS_PULSE   = 4;
    localparam int RAS_PRECH   = 3;
    localparam int CAS_SETUP   = 1;
    localparam int CAS_HOLD    = 2;
    localparam int BACKLOG_W   = 3;
    localparam int PAUSE_CLKS  = PAUSE_US * CLK_PER_US;
    localparam int INTERVAL    = CLK_PER_US * REFRESH_MS * 1000 / ROWS;
    localparam int WINDOW      = 100;

    // vector: {row_only, hold_intervals[3:0], expected_cycles[3:0]}
    localparam logic [8:0] VECS [0:5] = '{
        {1'b0, 4'd1, 4'd1},
        {1'b1, 4'd1, 4'd1},
        {1'b0, 4'd3, 4'd3},
        {1'b1, 4'd2, 4'd2},
        {1'b0, 4'd9, 4'd7},
        {1'b1, 4'd4, 4'd4}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_row_only = 1'b0;
    logic       grant = 1'b0;
    logic       req, ready, ras_n, cas_n, addr_oe;
    logic [7:0] row_addr;

    int checks = 0;
    int fails  = 0;

    dram_refresh_sched #(
        .CLK_PER_US (CLK_PER_US),
        .ROWS       (ROWS),
        .REFRESH_MS (REFRESH_MS),
        .PAUSE_US   (PAUSE_US),
        .INIT_CYCLES(INIT_CYCLES),
        .RAS_PULSE  (RAS_PULSE),
        .RAS_PRECH  (RAS_PRECH),
        .CAS_SETUP  (CAS_SETUP),
        .CAS_HOLD   (CAS_HOLD),
        .BACKLOG_W  (BACKLOG_W)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .mode_row_only(mode_row_only),
        .grant        (grant),
        .req          (req),
        .ready        (ready),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .row_addr     (row_addr),
        .addr_oe      (addr_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // ---------------- strobe monitor (negedge sampling) ----------------
    logic       exp_row = 1'b0;
    logic [7:0] model_row = 8'd0;
    int  rel_cnt, first_act, falls, falls_at_ready;
    int  ras_low_run, ras_high_run, cas_low_run, cas_in_ras;
    logic prev_ras, prev_ready;

    always @(negedge clk) begin
        if (rst) begin
            rel_cnt = 0; first_act = -1; falls = 0; falls_at_ready = -1;
            ras_low_run = 0; ras_high_run = 1000; cas_low_run = 0; cas_in_ras = 0;
            prev_ras = 1'b1; prev_ready = 1'b0;
            model_row = 8'd0;
        end else begin
            rel_cnt++;
            if (first_act < 0 && (!ras_n || !cas_n)) first_act = rel_cnt;
            if (ready && !prev_ready) falls_at_ready = falls;
            if (prev_ras && !ras_n) begin
                falls++;
                // R7 precharge
                chk(ras_high_run >= RAS_PRECH, "R7 precharge", ras_high_run, RAS_PRECH);
                if (!exp_row) begin
                    // R4 column strobe leads
                    chk(!cas_n && cas_low_run >= CAS_SETUP, "R4 cas setup", cas_low_run, CAS_SETUP);
                    // R5 no address driven
                    chk(!addr_oe, "R5 addr_oe", addr_oe, 0);
                end else begin
                    // R6 row-only address and strobes
                    chk(cas_n && addr_oe, "R6 strobes", {cas_n, addr_oe}, 3);
                    chk(row_addr == model_row, "R6 row address", row_addr, model_row);
                end
                cas_in_ras = 0;
            end
            if (!prev_ras && ras_n) begin
                // R7 pulse width
                chk(ras_low_run == RAS_PULSE, "R7 ras width", ras_low_run, RAS_PULSE);
                if (!exp_row) chk(cas_in_ras >= CAS_HOLD, "R4 cas hold", cas_in_ras, CAS_HOLD);
                else          model_row = model_row + 8'd1;
            end
            if (!ras_n && !cas_n) cas_in_ras++;
            ras_low_run  = ras_n ? 0 : ras_low_run + 1;
            ras_high_run = ras_n ? ras_high_run + 1 : 0;
            cas_low_run  = cas_n ? 0 : cas_low_run + 1;
            prev_ras   = ras_n;
            prev_ready = ready;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    task automatic check_reset_state();
        // R10
        chk(!ready && !req, "R10 ready/req", {ready, req}, 0);
        chk(ras_n && cas_n, "R10 strobes", {ras_n, cas_n}, 3);
        chk(row_addr == 8'd0, "R10 row counter", row_addr, 0);
    endtask

    task automatic bring_up();
        int waited;
        waited = 0;
        while (!ready && waited < 5000) begin
            @(negedge clk);
            waited++;
            if (!ready) chk(!req, "R3 req before ready", req, 0);
        end
        @(negedge clk);
        // R2 pause length
        chk(first_act >= PAUSE_CLKS && first_act <= PAUSE_CLKS + 4, "R2 first activity",
            first_act, PAUSE_CLKS);
        // R3 warm-up count
        chk(falls_at_ready == INIT_CYCLES, "R3 warm-up cycles", falls_at_ready, INIT_CYCLES);
    endtask

    task automatic rate_run(input bit row_only, input int k);
        int f0;
        grant = 1'b0;
        @(negedge clk);
        mode_row_only = row_only;
        exp_row = row_only;
        grant = 1'b1;
        @(posedge req);
        f0 = falls;
        repeat (k * INTERVAL) @(negedge clk);
        // R1 average rate
        chk(falls - f0 == k, "R1 refresh rate", falls - f0, k);
        grant = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        bring_up();

        // ---------------- table-driven backlog / grant vectors ----------------
        for (int v = 0; v < 6; v++) begin
            int  hold, expc, f0;
            bit  req_ok;
            hold = int'(VECS[v][7:4]);
            expc = int'(VECS[v][3:0]);
            mode_row_only = VECS[v][8];
            exp_row = VECS[v][8];
            grant = 1'b0;
            @(posedge req);
            f0 = falls;
            req_ok = 1'b1;
            repeat ((hold - 1) * INTERVAL + 10) begin
                @(negedge clk);
                if (!req) req_ok = 1'b0;
            end
            // R8 request held while not granted, nothing issued
            chk(req_ok, "R8 req held", req_ok, 1);
            chk(falls == f0, "R8 no cycle without grant", falls - f0, 0);
            grant = 1'b1;
            repeat (WINDOW) @(negedge clk);
            // R9 backlog drain (saturating)
            chk(falls - f0 == expc, "R9 backlog drain", falls - f0, expc);
            chk(!req, "R9 backlog empty", req, 0);
            grant = 1'b0;
        end

        // ---------------- directed tests ----------------
        rate_run(1'b0, 12);

        // reset mid-run, restart in row-only style
        @(negedge clk);
        rst = 1'b1;
        mode_row_only = 1'b1;
        exp_row = 1'b1;
        grant = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        bring_up();
        // R6 counter advanced once per warm-up row-only cycle
        chk(row_addr == 8'(INIT_CYCLES), "R6 counter after warm-up", row_addr, INIT_CYCLES);

        // long row-only run covers counter wrap
        rate_run(1'b1, 260);
        // R6 wrap modulo 256
        chk(row_addr == model_row, "R6 counter wrap", row_addr, model_row);

        finish_run();
    end

endmodule